// File: doc/BRIEF.md
# Secure Memory Write Gate

This block inspects every write request headed for a secure nonvolatile memory before any byte is allowed to reach the array. Each request is presented for one cycle with its start address, its byte count, a region code from the address decoder, the two lock bytes that guard the key and configuration areas, and one write-enable bit per user zone. One clock later the gate gives a single registered verdict: it issues a commit strobe when the write may go ahead, or it holds the array untouched and raises a sticky error flag.

The gate checks three things. The first is geometry: the byte count, the 32-byte physical page limit and the user-zone limits. The second is region policy: the zone permission bits, whole-record writes to the key area, and the lock on the configuration area. The third is one special address that does not touch the array and instead rewinds the command and response buffer pointers. The error flag stays set until the host reads the status register. The read clears it, except when a new rejection arrives in the same cycle.

Top module: `secwr_gate`

## Requirements
- R1: The verdict (`dec_valid`, `dec_accept`, `commit`, `buf_ptr_rst`) appears exactly one clock after a cycle with `req_valid` high, lasts one cycle, and `commit` is high only together with an accepting verdict.
- R2: A request whose byte count is 0 or greater than 32 is rejected.
- R3: A request is rejected when the low five address bits plus the byte count exceed 32, that is, when it leaves its 32-byte page.
- R4: A request with region code 2'b00 (user) is rejected when its first or last byte lies at or above address 0x1000, or when its first and last bytes fall in different 256-byte zones.
- R5: A user write that passes R2 to R4 is accepted exactly when `zone_wr_en[addr >> 8]` is 1.
- R6: A request with region code 2'b01 (key) is accepted only when `key_lock` equals 0x55, the low four address bits are zero and the count is exactly 16. Every other key write is rejected, including any made under a lock value other than 0x55.
- R7: A request with region code 2'b10 (configuration) that passes R2 and R3 is accepted only when `cfg_lock` equals 0x55. Any other lock value rejects it.
- R8: A request to address 0xFFFE is accepted whatever its count and region. It produces a one-cycle `buf_ptr_rst`, no `commit`, and no error.
- R9: A rejected request sets `eerr` in the same cycle as its verdict. `eerr` stays set until a cycle with `status_rd` high, and is clear from the following cycle.
- R10: When a rejected request and `status_rd` are sampled on the same clock edge, `eerr` is 1 after that edge.
- R11: After reset, all outputs are 0.
- R12: A request with region code 2'b11 (unmapped) is rejected unless its address is 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request strobe, one cycle per request |
| req_addr | input | 16 | Start byte address |
| req_count | input | 6 | Number of data bytes |
| req_region | input | 2 | Region code: 00 user, 01 key, 10 configuration, 11 unmapped |
| key_lock | input | 8 | Key-area lock byte, 0x55 means open |
| cfg_lock | input | 8 | Configuration lock byte, 0x55 means open |
| zone_wr_en | input | 16 | Write-enable bit for each 256-byte user zone |
| status_rd | input | 1 | Host reads the status register this cycle |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Verdict is accept |
| commit | output | 1 | Program strobe to the array |
| buf_ptr_rst | output | 1 | Rewind command and response buffer pointers |
| eerr | output | 1 | Sticky write-error status bit |

## Verification
The error flag has two writers that can act on the same clock edge: a rejected request sets it, and a host status read clears it. The bench provokes the collision on purpose. It raises `status_rd` in the very cycle it presents a request that must fail, and also in cycles with passing requests and with no request at all. The bench's own flag model gives priority to the set. It judges `eerr` one cycle later, so a lost error and a stale one are both caught.

// File: rtl/secwr_pkg.sv
// Package: shared types for the secure write gate.
// Assumes region codes come from an external address decoder.
package secwr_pkg;

    // Lock byte value that means "open"; every other value is locked.
    localparam logic [7:0] LOCK_OPEN = 8'h55;

    typedef enum logic [1:0] {
        RGN_USER = 2'b00,
        RGN_KEY  = 2'b01,
        RGN_CFG  = 2'b10,
        RGN_NONE = 2'b11
    } region_e;

    typedef struct packed {
        logic cnt_bad;
        logic page_cross;
        logic zone_span;
        logic zone_oob;
    } geom_flags_t;

endpackage

// File: rtl/secwr_geom.sv
// Geometry check: byte count range, page crossing and user-zone extent.
// Assumes PAGE_BYTES and ZONE_BYTES are powers of two and that
// ADDR_W is wider than CNT_W. Purely combinational.
module secwr_geom
    import secwr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 6,
    parameter int MAX_BYTES  = 32,
    parameter int PAGE_BYTES = 32,
    parameter int ZONE_BYTES = 256,
    parameter int N_ZONES    = 16,
    parameter int ZI_W       = (N_ZONES > 1) ? $clog2(N_ZONES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output geom_flags_t       flags,
    output logic [ZI_W-1:0]   zone_idx
);
    localparam int XW   = ADDR_W + 1;
    localparam int PO_W = $clog2(PAGE_BYTES);
    localparam int ZB_W = $clog2(ZONE_BYTES);

    logic [XW-1:0] a_ext, c_ext, last_byte, page_end, z_first, z_last;

    // Derive first/last byte, page end and zone numbers; flag violations.
    always_comb begin
        a_ext     = {1'b0, addr};
        c_ext     = XW'(count);
        last_byte = a_ext + c_ext - XW'(1);
        page_end  = XW'(addr[PO_W-1:0]) + c_ext;
        z_first   = a_ext >> ZB_W;
        z_last    = last_byte >> ZB_W;

        flags.cnt_bad    = (count == '0) || (count > CNT_W'(MAX_BYTES));
        flags.page_cross = page_end > XW'(PAGE_BYTES);
        flags.zone_oob   = (z_first >= XW'(N_ZONES)) || (z_last >= XW'(N_ZONES));
        flags.zone_span  = z_first != z_last;
        zone_idx         = z_first[ZI_W-1:0];
    end

endmodule

// File: rtl/secwr_policy.sv
// Policy check: combines geometry flags with region, lock bytes and
// zone permissions into one accept decision. Recognises the buffer
// pointer reset address, which bypasses every other rule.
// Assumes region codes per secwr_pkg::region_e. Purely combinational.
module secwr_policy
    import secwr_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          CNT_W        = 6,
    parameter int          KEY_REC      = 16,
    parameter int          N_ZONES      = 16,
    parameter int          ZI_W         = (N_ZONES > 1) ? $clog2(N_ZONES) : 1,
    parameter logic [15:0] BUF_RST_ADDR = 16'hFFFE
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   count,
    input  region_e            region,
    input  geom_flags_t        flags,
    input  logic [ZI_W-1:0]    zone_idx,
    input  logic [N_ZONES-1:0] zone_wr_en,
    input  logic [7:0]         key_lock,
    input  logic [7:0]         cfg_lock,
    output logic               accept,
    output logic               buf_hit
);
    localparam int KR_W = $clog2(KEY_REC);

    logic [N_ZONES-1:0] zone_hit;
    logic perm_ok, key_open, cfg_open, key_fit, geom_ok;

    // One comparator per zone: the selected zone's enable bit passes through.
    for (genvar z = 0; z < N_ZONES; z++) begin : g_zone
        assign zone_hit[z] = (zone_idx == ZI_W'(z)) && zone_wr_en[z];
    end

    // Evaluate the locks and the key-record shape, then pick the region rule.
    always_comb begin
        perm_ok  = |zone_hit;
        key_open = key_lock == LOCK_OPEN;
        cfg_open = cfg_lock == LOCK_OPEN;
        key_fit  = (addr[KR_W-1:0] == '0) && (count == CNT_W'(KEY_REC));
        geom_ok  = !flags.cnt_bad && !flags.page_cross;
        buf_hit  = addr == ADDR_W'(BUF_RST_ADDR);

        if (buf_hit) begin
            accept = 1'b1;
        end else if (!geom_ok) begin
            accept = 1'b0;
        end else begin
            unique case (region)
                RGN_USER: accept = !flags.zone_oob && !flags.zone_span && perm_ok;
                RGN_KEY:  accept = key_open && key_fit;
                RGN_CFG:  accept = cfg_open;
                default:  accept = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/secwr_errflag.sv
// Sticky error flag. Set has priority over clear so that an error
// arriving during a status read is never lost.
// Assumes set and clr are single-cycle qualifiers sampled at clk.
module secwr_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the error until read; a new rejection wins over the read.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/secwr_gate.sv
// Top level of the secure write gate. Registers a one-cycle verdict
// for each request strobe: commit on accept, pointer rewind for the
// buffer reset address, sticky error on reject.
// Assumes requests are at least one cycle apart or back to back, each
// held for exactly one cycle.
module secwr_gate
    import secwr_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          CNT_W        = 6,
    parameter int          MAX_BYTES    = 32,
    parameter int          PAGE_BYTES   = 32,
    parameter int          ZONE_BYTES   = 256,
    parameter int          N_ZONES      = 16,
    parameter int          KEY_REC      = 16,
    parameter logic [15:0] BUF_RST_ADDR = 16'hFFFE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [CNT_W-1:0]   req_count,
    input  logic [1:0]         req_region,
    input  logic [7:0]         key_lock,
    input  logic [7:0]         cfg_lock,
    input  logic [N_ZONES-1:0] zone_wr_en,
    input  logic               status_rd,
    output logic               dec_valid,
    output logic               dec_accept,
    output logic               commit,
    output logic               buf_ptr_rst,
    output logic               eerr
);
    localparam int ZI_W = (N_ZONES > 1) ? $clog2(N_ZONES) : 1;

    geom_flags_t       flags;
    logic [ZI_W-1:0]   zone_idx;
    logic              accept_c, buf_hit_c, reject_c;
    region_e           region;

    assign region   = region_e'(req_region);
    assign reject_c = req_valid && !accept_c;

    secwr_geom #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES),
        .PAGE_BYTES(PAGE_BYTES), .ZONE_BYTES(ZONE_BYTES),
        .N_ZONES(N_ZONES), .ZI_W(ZI_W)
    ) u_geom (
        .addr(req_addr), .count(req_count),
        .flags(flags), .zone_idx(zone_idx)
    );

    secwr_policy #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEY_REC(KEY_REC),
        .N_ZONES(N_ZONES), .ZI_W(ZI_W), .BUF_RST_ADDR(BUF_RST_ADDR)
    ) u_policy (
        .addr(req_addr), .count(req_count), .region(region),
        .flags(flags), .zone_idx(zone_idx), .zone_wr_en(zone_wr_en),
        .key_lock(key_lock), .cfg_lock(cfg_lock),
        .accept(accept_c), .buf_hit(buf_hit_c)
    );

    secwr_errflag u_err (
        .clk(clk), .rst_n(rst_n),
        .set(reject_c), .clr(status_rd),
        .flag(eerr)
    );

    // Register the verdict and its strobes one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            dec_accept  <= 1'b0;
            commit      <= 1'b0;
            buf_ptr_rst <= 1'b0;
        end else begin
            dec_valid   <= req_valid;
            dec_accept  <= req_valid && accept_c;
            commit      <= req_valid && accept_c && !buf_hit_c;
            buf_ptr_rst <= req_valid && buf_hit_c;
        end
    end

endmodule

// File: rtl/secwr_gate_chk.sv
// Assertion checker for secwr_gate, attached by bind below.
// Observes ports only.
module secwr_gate_chk #(
    parameter int          ADDR_W       = 16,
    parameter int          CNT_W        = 6,
    parameter int          MAX_BYTES    = 32,
    parameter int          KEY_REC      = 16,
    parameter logic [15:0] BUF_RST_ADDR = 16'hFFFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CNT_W-1:0]  req_count,
    input logic [1:0]        req_region,
    input logic [7:0]        cfg_lock,
    input logic              status_rd,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic              commit,
    input logic              buf_ptr_rst,
    input logic              eerr
);
    localparam int KR_W = $clog2(KEY_REC);

    logic not_buf;
    assign not_buf = req_addr != ADDR_W'(BUF_RST_ADDR);

    AST_VERDICT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);  // R1
    AST_NO_IDLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid);  // R1
    AST_COMMIT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (dec_valid && dec_accept));  // R1
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && not_buf && (req_count == '0 || req_count > CNT_W'(MAX_BYTES)))
        |=> !dec_accept);  // R2
    AST_KEY_WHOLE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && not_buf && req_region == 2'b01 &&
         (req_addr[KR_W-1:0] != '0 || req_count != CNT_W'(KEY_REC)))
        |=> !commit);  // R6
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && not_buf && req_region == 2'b10 && cfg_lock != 8'h55)
        |=> !commit);  // R7
    AST_BUF_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !not_buf) |=> (buf_ptr_rst && dec_accept && !commit));  // R8
    AST_REWIND_NOT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_ptr_rst |-> !commit);  // R8
    AST_ERR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> eerr);  // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eerr && !status_rd) |=> eerr);  // R9
    AST_ERR_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !req_valid) |=> !eerr);  // R9
    AST_NO_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && not_buf && req_region == 2'b11) |=> !dec_accept);  // R12

endmodule

bind secwr_gate secwr_gate_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES),
    .KEY_REC(KEY_REC), .BUF_RST_ADDR(BUF_RST_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_count(req_count), .req_region(req_region), .cfg_lock(cfg_lock),
    .status_rd(status_rd), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .commit(commit), .buf_ptr_rst(buf_ptr_rst), .eerr(eerr)
);

// File: tb/secwr_gate_test.sv
`timescale 1ns/1ps
module secwr_gate_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_addr;
    logic [5:0]  req_count;
    logic [1:0]  req_region;
    logic [7:0]  key_lock, cfg_lock;
    logic [15:0] zone_wr_en;
    logic        status_rd;
    logic        dec_valid, dec_accept, commit, buf_ptr_rst, eerr;

    int  n_checks = 0;
    int  n_fail   = 0;
    logic exp_err = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    secwr_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .req_region(req_region), .key_lock(key_lock),
        .cfg_lock(cfg_lock), .zone_wr_en(zone_wr_en), .status_rd(status_rd),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .commit(commit),
        .buf_ptr_rst(buf_ptr_rst), .eerr(eerr)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Reference decision from the requirements; tag names the deciding rule.
    function automatic logic model(input int a, input int c, input int r,
                                   input int kl, input int cl, input logic [15:0] zen,
                                   output string tag);
        int last;
        last = a + c - 1;
        if (a == 16'hFFFE) begin tag = "R8"; return 1'b1; end
        if (c == 0 || c > 32) begin tag = "R2"; return 1'b0; end
        if ((a % 32) + c > 32) begin tag = "R3"; return 1'b0; end
        case (r)
            0: begin
                tag = "R4";
                if (a >= 4096 || last >= 4096) return 1'b0;
                if ((a / 256) != (last / 256)) return 1'b0;
                tag = "R5";
                return zen[a / 256];
            end
            1: begin tag = "R6"; return (kl == 8'h55) && (a % 16 == 0) && (c == 16); end
            2: begin tag = "R7"; return cl == 8'h55; end
            default: begin tag = "R12"; return 1'b0; end
        endcase
    endfunction

    // Present one request (optionally with a status read), then check the verdict.
    task automatic do_req(input logic [15:0] a, input logic [5:0] c, input logic [1:0] r,
                          input logic [7:0] kl, input logic [7:0] cl,
                          input logic [15:0] zen, input logic rd);
        string tag;
        logic  acc, isbuf;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_count = c; req_region = r;
        key_lock = kl; cfg_lock = cl; zone_wr_en = zen; status_rd = rd;
        acc   = model(int'(a), int'(c), int'(r), int'(kl), int'(cl), zen, tag);
        isbuf = (a == 16'hFFFE);
        if (!acc)    exp_err = 1'b1;
        else if (rd) exp_err = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; status_rd = 1'b0;
        check("R1", "dec_valid", dec_valid, 1'b1);
        check(tag, "dec_accept", dec_accept, acc);
        check(tag, "commit", commit, acc && !isbuf);
        check("R8", "buf_ptr_rst", buf_ptr_rst, isbuf);
        check((!acc && rd) ? "R10" : "R9", "eerr", eerr, exp_err);
    endtask

    task automatic idle(input logic rd);
        @(negedge clk);
        status_rd = rd;
        if (rd) exp_err = 1'b0;
        @(negedge clk);
        status_rd = 1'b0;
        check("R1", "dec_valid idle", dec_valid, 1'b0);
        check("R9", "eerr idle", eerr, exp_err);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EC0_0A11));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_count = '0;
        req_region = '0; key_lock = '0; cfg_lock = '0; zone_wr_en = '0; status_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "dec_valid reset", dec_valid, 1'b0);
        check("R11", "dec_accept reset", dec_accept, 1'b0);
        check("R11", "commit reset", commit, 1'b0);
        check("R11", "buf_ptr_rst reset", buf_ptr_rst, 1'b0);
        check("R11", "eerr reset", eerr, 1'b0);
        rst_n = 1'b1;

        // R2: count bounds
        do_req(16'h0000, 6'd0,  2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b0);
        idle(1'b1);
        do_req(16'h0000, 6'd33, 2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b1);
        do_req(16'h0000, 6'd32, 2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b1);
        // R3: page edge
        do_req(16'h001E, 6'd3,  2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b1);
        do_req(16'h001E, 6'd2,  2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b1);
        // R4: user range end
        do_req(16'h0FF0, 6'd16, 2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b0);
        do_req(16'h1000, 6'd1,  2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b1);
        // R5: zone permission
        do_req(16'h0340, 6'd4,  2'b00, 8'h00, 8'h00, 16'hFFF7, 1'b1);
        do_req(16'h0340, 6'd4,  2'b00, 8'h00, 8'h00, 16'h0008, 1'b1);
        // R6: key records
        do_req(16'h0020, 6'd16, 2'b01, 8'h55, 8'h00, 16'h0000, 1'b0);
        do_req(16'h0028, 6'd16, 2'b01, 8'h55, 8'h00, 16'h0000, 1'b1);
        do_req(16'h0020, 6'd15, 2'b01, 8'h55, 8'h00, 16'h0000, 1'b1);
        do_req(16'h0020, 6'd16, 2'b01, 8'h00, 8'h00, 16'h0000, 1'b1);
        do_req(16'h0020, 6'd16, 2'b01, 8'h54, 8'h00, 16'h0000, 1'b1);
        // R7: configuration lock
        do_req(16'h0010, 6'd8,  2'b10, 8'h00, 8'h55, 16'h0000, 1'b1);
        do_req(16'h0010, 6'd8,  2'b10, 8'h00, 8'h00, 16'h0000, 1'b1);
        do_req(16'h0010, 6'd8,  2'b10, 8'h00, 8'hAA, 16'h0000, 1'b1);
        // R8: buffer rewind, even with bad count and locked region
        do_req(16'hFFFE, 6'd0,  2'b10, 8'h00, 8'h00, 16'h0000, 1'b1);
        do_req(16'hFFFE, 6'd40, 2'b11, 8'h00, 8'h00, 16'h0000, 1'b0);
        // R12: unmapped region
        do_req(16'h0000, 6'd4,  2'b11, 8'h55, 8'h55, 16'hFFFF, 1'b0);
        // R9: error sticks through idle cycles, then clears on read
        idle(1'b0);
        idle(1'b0);
        idle(1'b1);
        // R10: reject arriving with a status read keeps the error
        do_req(16'h0000, 6'd0,  2'b00, 8'h00, 8'h00, 16'hFFFF, 1'b1);
        idle(1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [5:0]  c;
            logic [7:0]  kl, cl;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0)      a = 16'hFFFE;
            else if (sel < 3)  a = 16'($urandom);
            else if (sel < 6)  a = 16'($urandom_range(0, 4095));
            else               a = 16'(($urandom_range(0, 127) * 32) + $urandom_range(0, 31));
            sel = $urandom_range(0, 5);
            if (sel == 0)      c = 6'd16;
            else if (sel < 4)  c = 6'($urandom_range(1, 32));
            else               c = 6'($urandom_range(0, 40));
            if ($urandom_range(0, 4) == 0) a[3:0] = 4'h0;
            sel = $urandom_range(0, 2);
            kl = (sel == 0) ? 8'h55 : (sel == 1) ? 8'h00 : 8'($urandom);
            sel = $urandom_range(0, 2);
            cl = (sel == 0) ? 8'h55 : (sel == 1) ? 8'h00 : 8'($urandom);
            do_req(a, c, 2'($urandom_range(0, 3)), kl, cl, 16'($urandom),
                   ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 7) == 0) idle($urandom_range(0, 1) == 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule